// File: doc/BRIEF.md
# Presettable Down Counter Channel with Count Latch

This block is a single channel of an interval timer. A 16-bit register counts down on each falling edge of its own counting clock `cntClk` while `gate` is high. It counts either in plain binary or as four BCD digits. A host reaches it through a byte-wide port that is qualified by an active-low chip select. With `a0` high, a write carries a control byte. With `a0` low, the host writes or reads the count.

The output runs in rate-generator fashion. `outPin` stays high and drops for one counting-clock period when the count reaches one. On the next counting edge the counter reloads. A latch command freezes a snapshot of the count, so the host can read it while counting goes on. A count that the host writes takes effect only on the first falling `cntClk` edge after the write completes.

Top module: `ptimer_chan`

## Requirements
- R1: After reset, `outPin` is high, the channel is not counting, binary mode with low-then-high byte access is selected, and `dataOut` is 0x00.
- R2: A write with `a0`=1 whose bits [2:1] are not 00 is a control byte. Bit 0 selects BCD (1) or binary (0). Bits [2:1] select access: 01 low byte only, 10 high byte only, 11 low then high. A control byte stops counting, forces `outPin` high, clears the byte toggles and releases any held latch, until a new count is loaded.
- R3: While `csN` is high, no write or read has any effect, and `dataOut` is 0x00.
- R4: A count write in low-only mode sets the reload value to {0x00, byte}. In high-only mode it sets {byte, 0x00}. In low-then-high mode the first byte is the low byte and the second byte completes the value.
- R5: A completed count write is moved into the counter on the first falling `cntClk` edge after it. Before that edge the counter keeps its previous value and keeps stepping.
- R6: In binary mode each falling `cntClk` edge with `gate` high lowers a loaded count by one. While `gate` is low the count holds.
- R7: In BCD mode each step decrements the lowest digit, and a digit at 0 becomes 9 and borrows from the next digit.
- R8: `outPin` is low exactly while the loaded count equals 1. The step from 1 reloads the last loaded count, so the period is N counting clocks.
- R9: An initial count of 0 acts as 65536 in binary (next value 0xFFFF) and as 10000 in BCD (next value 0x9999).
- R10: A write with `a0`=1 and bits [2:1]=00 captures the current count. Count reads then return the captured value while counting continues.
- R11: Once captured, the snapshot is held until it has been fully read: one read in a single-byte mode, two reads in low-then-high mode. Further capture commands are ignored until then. After that, reads return the live count.
- R12: Reads with `a0`=1 return 0x00, because the control byte cannot be read back.
- R13: Reads follow the access mode. In low-then-high mode a toggle returns the low byte first and then the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select |
| wrN | input | 1 | Active-low write strobe, one access per clk cycle |
| rdN | input | 1 | Active-low read strobe, one access per clk cycle |
| a0 | input | 1 | 1 = control byte, 0 = count byte |
| dataIn | input | 8 | Write data from host |
| dataOut | output | 8 | Read data; 0x00 when no count read is active |
| cntClk | input | 1 | Counting clock; falling edges are detected on clk |
| gate | input | 1 | Counting enable, active high |
| outPin | output | 1 | Rate-generator output, low for one count period |

## Verification
The counter is loaded with small binary counts so that many reload periods pass, and each period shows the exact length and placement of the low pulse. It is also loaded with a BCD value just above a hundred, which forces a borrow across two digits, and with zero in both number systems, which exposes the wrap to the largest value. Live and latched reads taken mid-count tell the snapshot apart from the running value. A repeated latch command separates "held until read" from "recaptured". Gate-low intervals, chip-deselected writes and reads of the control address each show that the input leaves the observed count and output unchanged.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int CNT_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int DIGIT_W = 4;
  localparam int DIGITS  = CNT_W / DIGIT_W;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_BOTH  = 2'b11
  } acc_e;

  typedef struct packed {
    logic loadCount;
    logic stepCount;
    logic captureLatch;
    logic bcdMode;
  } dp_strobe_t;
endpackage

// File: rtl/ptc_ctrl.sv
module ptc_ctrl
  import ptc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csN,
  input  logic                wrN,
  input  logic                rdN,
  input  logic                a0,
  input  logic [BYTE_W-1:0]   dataIn,
  input  logic                cntClk,
  input  logic                gate,
  input  logic [CNT_W-1:0]    countVal,
  input  logic [CNT_W-1:0]    latchVal,
  output dp_strobe_t          strb,
  output logic [CNT_W-1:0]    reloadVal,
  output logic                loaded,
  output logic [BYTE_W-1:0]   dataOut
);
  logic              cntClkQ, cntFall;
  logic              wrStb, rdStb, ctrlWr, latchCmd, cntWr, cntRd;
  acc_e              accMode;
  logic              bcdQ, pending, wrHi, rdHi, latchHeld;
  logic [BYTE_W-1:0] wrLo;
  logic [CNT_W-1:0]  readSrc;
  logic              hiSel;

  assign wrStb    = !csN && !wrN;
  assign rdStb    = !csN && !rdN;
  assign ctrlWr   = wrStb && a0 && (dataIn[2:1] != ACC_LATCH);
  assign latchCmd = wrStb && a0 && (dataIn[2:1] == ACC_LATCH);
  assign cntWr    = wrStb && !a0;
  assign cntRd    = rdStb && !a0;
  assign cntFall  = cntClkQ && !cntClk;

  always_comb begin
    strb.loadCount    = cntFall && pending;
    strb.stepCount    = cntFall && !pending && loaded && gate;
    strb.captureLatch = latchCmd && !latchHeld;
    strb.bcdMode      = bcdQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntClkQ   <= 1'b0;
      accMode   <= ACC_BOTH;
      bcdQ      <= 1'b0;
      pending   <= 1'b0;
      loaded    <= 1'b0;
      wrHi      <= 1'b0;
      rdHi      <= 1'b0;
      latchHeld <= 1'b0;
      wrLo      <= '0;
      reloadVal <= '0;
    end else begin
      cntClkQ <= cntClk;
      if (strb.loadCount) begin
        loaded  <= 1'b1;
        pending <= 1'b0;
      end
      if (strb.captureLatch) latchHeld <= 1'b1;
      if (cntWr) begin
        unique case (accMode)
          ACC_LO: begin
            reloadVal <= {{(CNT_W-BYTE_W){1'b0}}, dataIn};
            pending   <= 1'b1;
          end
          ACC_HI: begin
            reloadVal <= {dataIn, {(CNT_W-BYTE_W){1'b0}}};
            pending   <= 1'b1;
          end
          default: begin
            if (!wrHi) begin
              wrLo <= dataIn;
              wrHi <= 1'b1;
            end else begin
              reloadVal <= {dataIn, wrLo};
              wrHi      <= 1'b0;
              pending   <= 1'b1;
            end
          end
        endcase
      end
      if (cntRd) begin
        if (accMode == ACC_BOTH) begin
          rdHi <= !rdHi;
          if (rdHi) latchHeld <= 1'b0;
        end else begin
          latchHeld <= 1'b0;
        end
      end
      if (ctrlWr) begin
        accMode   <= acc_e'(dataIn[2:1]);
        bcdQ      <= dataIn[0];
        loaded    <= 1'b0;
        pending   <= 1'b0;
        wrHi      <= 1'b0;
        rdHi      <= 1'b0;
        latchHeld <= 1'b0;
      end
    end
  end

  assign readSrc = latchHeld ? latchVal : countVal;
  assign hiSel   = (accMode == ACC_HI) || ((accMode == ACC_BOTH) && rdHi);
  assign dataOut = cntRd ? (hiSel ? readSrc[CNT_W-1 -: BYTE_W] : readSrc[BYTE_W-1:0]) : '0;

  AST_CS_BLOCKS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    csN |=> ($stable(accMode) && $stable(bcdQ))) else $error("cs"); // R3
  AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (latchHeld && !cntRd && !ctrlWr) |=> latchHeld) else $error("held"); // R11
  AST_LOAD_MARKS_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.loadCount && !ctrlWr) |=> loaded) else $error("loaded"); // R5
  AST_CTRL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlWr |=> (!loaded && !pending)) else $error("stop"); // R2
endmodule

// File: rtl/ptc_datapath.sv
module ptc_datapath
  import ptc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dp_strobe_t        strb,
  input  logic [CNT_W-1:0]  reloadVal,
  input  logic              loaded,
  output logic [CNT_W-1:0]  countVal,
  output logic [CNT_W-1:0]  latchVal,
  output logic              outPin
);
  logic [CNT_W-1:0] binDec, bcdDec, nextStep;
  logic [DIGITS:0]  borrow;
  logic             atOne;

  assign binDec    = countVal - 1'b1;
  assign borrow[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [DIGIT_W-1:0] digit;
    assign digit = countVal[g*DIGIT_W +: DIGIT_W];
    assign bcdDec[g*DIGIT_W +: DIGIT_W] =
      !borrow[g] ? digit : ((digit == '0) ? DIGIT_W'(9) : digit - 1'b1);
    assign borrow[g+1] = borrow[g] && (digit == '0);
  end

  assign atOne    = (countVal == CNT_W'(1));
  assign nextStep = atOne ? reloadVal : (strb.bcdMode ? bcdDec : binDec);
  assign outPin   = !(loaded && atOne);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      countVal <= '0;
      latchVal <= '0;
    end else begin
      if (strb.loadCount)      countVal <= reloadVal;
      else if (strb.stepCount) countVal <= nextStep;
      if (strb.captureLatch)   latchVal <= countVal;
    end
  end

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadCount |=> (countVal == $past(reloadVal))) else $error("load"); // R5
  AST_BIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.stepCount && !strb.bcdMode && countVal != CNT_W'(1)) |=>
      (countVal == $past(countVal) - 1'b1)) else $error("bin"); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.loadCount && !strb.stepCount) |=> $stable(countVal)) else $error("hold"); // R6
  AST_BCD_LOW_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.stepCount && strb.bcdMode && countVal[3:0] != 4'd0 && countVal != CNT_W'(1)) |=>
      (countVal[3:0] == $past(countVal[3:0]) - 4'd1)) else $error("bcd"); // R7
  AST_RELOAD_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.stepCount && countVal == CNT_W'(1)) |=> (countVal == $past(reloadVal))) else $error("reload"); // R8
  AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.captureLatch |=> $stable(latchVal)) else $error("latch"); // R10
endmodule

// File: rtl/ptimer_chan.sv
module ptimer_chan
  import ptc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csN,
  input  logic              wrN,
  input  logic              rdN,
  input  logic              a0,
  input  logic [BYTE_W-1:0] dataIn,
  output logic [BYTE_W-1:0] dataOut,
  input  logic              cntClk,
  input  logic              gate,
  output logic              outPin
);
  dp_strobe_t       strb;
  logic [CNT_W-1:0] countVal, latchVal, reloadVal;
  logic             loaded;

  ptc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .csN(csN), .wrN(wrN), .rdN(rdN), .a0(a0),
    .dataIn(dataIn), .cntClk(cntClk), .gate(gate), .countVal(countVal),
    .latchVal(latchVal), .strb(strb), .reloadVal(reloadVal),
    .loaded(loaded), .dataOut(dataOut)
  );

  ptc_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .reloadVal(reloadVal),
    .loaded(loaded), .countVal(countVal), .latchVal(latchVal), .outPin(outPin)
  );

  AST_OUT_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> outPin) else $error("out"); // R8
endmodule

// File: tb/ptimer_chan_bench.sv
module ptimer_chan_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       csN = 1'b1, wrN = 1'b1, rdN = 1'b1, a0 = 1'b0;
  logic       cntClk = 1'b0, gate = 1'b1;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] dataOut;
  logic       outPin;

  int    compared = 0, mismatched = 0;
  string curTag = "R13";
  bit    done = 1'b0;

  // reference model state
  int mCount = 0, mReload = 0, mLatch = 0, mWrLo = 0, mAcc = 3;
  bit mBcd = 0, mLoaded = 0, mPending = 0, mWrHi = 0, mRdHi = 0, mLatchHeld = 0, mPrev = 0;
  int phaseCnt = 0;

  ptimer_chan u_ptimer_chan (
    .clk(clk), .rst_n(rst_n), .csN(csN), .wrN(wrN), .rdN(rdN), .a0(a0),
    .dataIn(dataIn), .dataOut(dataOut), .cntClk(cntClk), .gate(gate), .outPin(outPin)
  );

  always #2 clk = ~clk;

  function automatic int bcd2int(input int v);
    int r = 0;
    for (int i = 3; i >= 0; i--) r = r * 10 + ((v >> (4 * i)) & 15);
    return r;
  endfunction

  function automatic int int2bcd(input int v);
    int r = 0;
    for (int i = 0; i < 4; i++) begin
      r = r | ((v % 10) << (4 * i));
      v = v / 10;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // counting clock: period of six system clocks
  always @(negedge clk) begin
    phaseCnt++;
    if (phaseCnt == 3) begin
      phaseCnt = 0;
      cntClk = ~cntClk;
    end
  end

  // behavioural reference, advanced on every rising clock
  always @(posedge clk) begin
    bit fall, wr, rd, oldPend, oldLoaded, oldBcd, ctrlW, newPend;
    int oldReload;
    if (!rst_n) begin
      mCount = 0; mReload = 0; mLatch = 0; mWrLo = 0; mAcc = 3;
      mBcd = 0; mLoaded = 0; mPending = 0; mWrHi = 0; mRdHi = 0; mLatchHeld = 0; mPrev = 0;
    end else begin
      fall = mPrev && !cntClk;
      mPrev = cntClk;
      wr = !csN && !wrN;
      rd = !csN && !rdN;
      oldPend = mPending; oldLoaded = mLoaded; oldBcd = mBcd; oldReload = mReload;
      ctrlW = 0; newPend = 0;
      if (wr && a0) begin
        if (dataIn[2:1] == 2'b00) begin
          if (!mLatchHeld) begin mLatch = mCount; mLatchHeld = 1; end
        end else begin
          mBcd = dataIn[0]; mAcc = int'(dataIn[2:1]);
          mLoaded = 0; mPending = 0; mWrHi = 0; mRdHi = 0; mLatchHeld = 0; ctrlW = 1;
        end
      end
      if (wr && !a0) begin
        if (mAcc == 1) begin mReload = int'(dataIn); mPending = 1; newPend = 1; end
        else if (mAcc == 2) begin mReload = int'(dataIn) * 256; mPending = 1; newPend = 1; end
        else if (!mWrHi) begin mWrLo = int'(dataIn); mWrHi = 1; end
        else begin mReload = int'(dataIn) * 256 + mWrLo; mWrHi = 0; mPending = 1; newPend = 1; end
      end
      if (rd && !a0) begin
        if (mAcc == 3) begin
          if (mRdHi) mLatchHeld = 0;
          mRdHi = !mRdHi;
        end else mLatchHeld = 0;
      end
      if (fall && oldPend) begin
        mCount = oldReload;
        if (!ctrlW) mLoaded = 1;
        if (!newPend) mPending = 0;
      end else if (fall && oldLoaded && gate) begin
        if (mCount == 1) mCount = oldReload;
        else if (oldBcd) mCount = int2bcd((bcd2int(mCount) + 9999) % 10000);
        else mCount = (mCount + 65535) % 65536;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    int src, expB;
    bit hi;
    #1;
    if (rst_n && !done) begin
      chk("R8 outPin", int'(outPin), int'(!(mLoaded && mCount == 1)));
      if (!csN && !rdN) begin
        if (a0) expB = 0;
        else begin
          src = mLatchHeld ? mLatch : mCount;
          hi = (mAcc == 2) || (mAcc == 3 && mRdHi);
          expB = hi ? ((src >> 8) & 255) : (src & 255);
        end
        chk(curTag, int'(dataOut), expB);
      end else begin
        chk("R3 idle dataOut", int'(dataOut), 0);
      end
    end
  end

  task automatic hostWr(input logic addr, input logic [7:0] d);
    @(negedge clk);
    csN = 0; wrN = 0; a0 = addr; dataIn = d;
    @(negedge clk);
    csN = 1; wrN = 1;
  endtask

  task automatic hostRd(input logic addr, input string tag);
    @(negedge clk);
    curTag = tag; csN = 0; rdN = 0; a0 = addr;
    @(negedge clk);
    csN = 1; rdN = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    #1;
    chk("R1 outPin", int'(outPin), 1);
    chk("R1 dataOut", int'(dataOut), 0);
    // R2 R4 R13: binary, low then high, count 5
    hostWr(1, 8'h06); hostWr(0, 8'h05); hostWr(0, 8'h00);
    idle(70);
    hostRd(0, "R13 low"); hostRd(0, "R13 high");
    // R5: new count mid-run, takes effect at next falling edge
    hostWr(0, 8'h09); hostWr(0, 8'h00);
    hostRd(0, "R5 low"); hostRd(0, "R5 high");
    idle(40);
    // R6: gate low holds the count
    gate = 0; idle(40);
    hostRd(0, "R6 low"); hostRd(0, "R6 high");
    gate = 1; idle(60);
    // R10 R11: latch, repeated latch ignored, release after two reads
    hostWr(1, 8'h00); idle(20);
    hostWr(1, 8'h00); idle(20);
    hostRd(0, "R10 low"); hostRd(0, "R11 high");
    idle(7);
    hostRd(0, "R11 live low"); hostRd(0, "R11 live high");
    // R4: low-only and high-only access
    hostWr(1, 8'h02); hostWr(0, 8'h04); idle(80);
    hostRd(0, "R4 lo-only"); hostRd(0, "R4 lo-only");
    hostWr(1, 8'h04); hostWr(0, 8'h01); idle(40);
    hostRd(0, "R4 hi-only");
    hostWr(1, 8'h00); idle(13);
    hostRd(0, "R10 hi-only latch"); hostRd(0, "R11 hi-only live");
    // R7: BCD 0103 borrows across two digits
    hostWr(1, 8'h07); hostWr(0, 8'h03); hostWr(0, 8'h01); idle(60);
    hostRd(0, "R7 low"); hostRd(0, "R7 high");
    // R8: short binary period
    hostWr(1, 8'h06); hostWr(0, 8'h03); hostWr(0, 8'h00); idle(100);
    // R9: zero count in BCD and binary
    hostWr(1, 8'h07); hostWr(0, 8'h00); hostWr(0, 8'h00); idle(30);
    hostRd(0, "R9 bcd low"); hostRd(0, "R9 bcd high");
    hostWr(1, 8'h06); hostWr(0, 8'h00); hostWr(0, 8'h00); idle(30);
    hostRd(0, "R9 bin low"); hostRd(0, "R9 bin high");
    // R3: deselected writes ignored
    @(negedge clk); csN = 1; wrN = 0; a0 = 1; dataIn = 8'h03;
    @(negedge clk); a0 = 0; dataIn = 8'h11;
    @(negedge clk); wrN = 1;
    idle(10);
    hostRd(0, "R3 low"); hostRd(0, "R3 high");
    // R12: control byte is not readable
    hostRd(1, "R12");
    // R2: control byte stops counting and holds the count
    hostWr(1, 8'h06); idle(30);
    hostRd(0, "R2 low"); hostRd(0, "R2 high");
    idle(20);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule